// File: doc/BRIEF.md
# I2C Command Sequencer with Framed Transmit Queue

This block sits between a software-filled transmit queue and an I2C bit engine. Each queue entry is ten bits wide: a byte plus two framing flags. The sequencer reads entries in order and turns them into one byte-level command at a time for the bit engine: start, repeated start, write a byte, read a byte with a chosen acknowledge, or stop. The bit engine handles the SCL and SDA timing. Received bytes go from the bit engine to a receive queue that lies outside this block.

An entry with its start flag set is an address byte. Bits 7:1 hold the 7-bit address and bit 0 gives the direction. For a write, later entries without the start flag are sent as data, and a stop follows any byte whose stop flag is set. For a read, the entry after the address is a byte count and not data. Its stop flag chooses whether the bus is released after the last byte. If an address or a written byte gets no acknowledge, the sequencer pulses an error, discards the rest of the queue and releases the bus.

Entries enter through a valid/ready port. An entry moves on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is low while the queue is full and in the cycle of an error flush. `in_data` must stay stable while `in_valid` waits. Commands leave through a second valid/ready port. The bit engine reports the end of each accepted command with a single-cycle `rsp_valid`, at least one cycle after acceptance.

Top module: `i2c_cmd_seq`

## Requirements
- R1: The queue holds DEPTH (16) entries and delivers them in order. `in_ready` is low whenever 16 entries are held, and no entry is lost while the queue has space.
- R2: When the queue is empty, `fifo_empty` is 1 and `occ_m1` is 0. When it holds n entries (n ≥ 1), `fifo_empty` is 0 and `occ_m1` is n-1.
- R3: An entry with bit 8 set issues a command with `cmd_op`=1 (start) if the bus is not owned, or `cmd_op`=2 (repeated start) if it is owned. This is followed by a write command (`cmd_op`=3) whose `cmd_byte` is the entry's bits 7:0. Bit 0 of that byte selects read (1) or write (0).
- R4: In a write transfer, each later entry with bit 8 clear is sent as a write command with `cmd_byte` equal to its bits 7:0. If the entry's bit 9 is set, a stop command (`cmd_op`=5) follows that byte.
- R5: A write address entry with bits 8 and 9 both set produces only start, the address write, and stop.
- R6: After a read address, the next entry's bits 7:0 give a count N. Exactly N read commands (`cmd_op`=4) follow. `cmd_nack` is 0 on all of them except the last, where it is 1. N=0 issues no read. If the count entry's bit 9 is set, a stop follows; otherwise the bus stays owned.
- R7: If the queue runs empty during a write with no stop pending, `bus_owned` stays 1 and no command is offered until a new entry arrives. The transfer then continues.
- R8: If the response to an address write or a data write has `rsp_nack`=1, `tx_err` pulses for one cycle. In that same cycle the queue reads empty, and the next command is a stop.
- R9: When a stop command completes, `bus_idle` pulses for one cycle and `bus_owned` goes low in that same cycle.
- R10: An entry with bit 8 clear that arrives when no write transfer is open is discarded without issuing any command.
- R11: While `cmd_valid` is high and `cmd_ready` is low, `cmd_op`, `cmd_byte` and `cmd_nack` hold steady. Only one command is in flight: the next is offered only after `rsp_valid`. `cmd_byte` is meaningful only for write commands, and `cmd_nack` only for read commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Queue entry offered |
| in_ready | output | 1 | Queue can take an entry |
| in_data | input | 10 | Entry: bit 9 stop, bit 8 start, bits 7:0 byte |
| occ_m1 | output | 4 | Entry count minus one (0 when empty) |
| fifo_empty | output | 1 | Queue holds no entry |
| cmd_valid | output | 1 | Command offered to bit engine |
| cmd_ready | input | 1 | Bit engine takes the command |
| cmd_op | output | 3 | 1 start, 2 repeated start, 3 write, 4 read, 5 stop |
| cmd_byte | output | 8 | Byte to write |
| cmd_nack | output | 1 | For reads: answer the byte with NACK |
| rsp_valid | input | 1 | Accepted command finished |
| rsp_nack | input | 1 | For writes: no acknowledge seen |
| bus_owned | output | 1 | This master holds the bus |
| tx_err | output | 1 | Missing-acknowledge pulse |
| bus_idle | output | 1 | Stop completed, bus released |

## Verification
The bench fills the queue against a stalled bit engine to walk the occupancy through every level up to full. A wrong offset or a missing full guard shows up as a wrong `occ_m1` or an entry accepted into a full queue. It sweeps read counts from zero up, which catches a counter that places the NACK one byte early or late, or that issues a read for a zero count. It mixes repeated starts, open writes that drain the queue, and stray data entries; a decoder that confuses the flags would issue start instead of repeated start or send a byte it should drop. It then refuses acknowledges on the address and on a mid-stream byte, where a design that does not flush would keep sending queued bytes after the error.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;
  typedef enum logic [2:0] {
    OP_NONE    = 3'd0,
    OP_START   = 3'd1,
    OP_RESTART = 3'd2,
    OP_WRITE   = 3'd3,
    OP_READ    = 3'd4,
    OP_STOP    = 3'd5
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_ADDR, ST_DATA, ST_CNT, ST_READ, ST_STOP
  } st_e;

  localparam int START_BIT = 8;
  localparam int STOP_BIT  = 9;
endpackage

// File: rtl/i2c_seq_fifo.sv
module i2c_seq_fifo #(
  parameter int W     = 10,
  parameter int DEPTH = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         flush,
  input  logic                         push,
  input  logic [W-1:0]                 push_data,
  input  logic                         pop,
  output logic [W-1:0]                 head,
  output logic                         empty,
  output logic                         full,
  output logic [$clog2(DEPTH+1)-1:0]   count
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  assign head  = mem[rp];
  assign empty = (cnt == '0);
  assign full  = (cnt == CW'(DEPTH));
  assign count = cnt;

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      cnt <= cnt + CW'(push) - CW'(pop);
    end
  end
endmodule

// File: rtl/i2c_seq_rdcnt.sv
module i2c_seq_rdcnt #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] load_val,
  input  logic          dec,
  output logic          zero,
  output logic          last
);
  logic [DW-1:0] rem;

  assign zero = (rem == '0);
  assign last = (rem == DW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)               rem <= '0;
    else if (load)            rem <= load_val;
    else if (dec && !zero)    rem <= rem - 1'b1;
  end
endmodule

// File: rtl/i2c_seq_ctrl.sv
module i2c_seq_ctrl
  import i2c_seq_pkg::*;
#(
  parameter int DW = 8,
  parameter int EW = DW + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [EW-1:0] head,
  input  logic          empty,
  output logic          pop,
  output logic          flush,
  output logic          cnt_load,
  output logic [DW-1:0] cnt_val,
  output logic          cnt_dec,
  input  logic          cnt_zero,
  input  logic          cnt_last,
  output logic          cmd_valid,
  input  logic          cmd_ready,
  output logic [2:0]    cmd_op,
  output logic [DW-1:0] cmd_byte,
  output logic          cmd_nack,
  input  logic          rsp_valid,
  input  logic          rsp_nack,
  output logic          bus_owned,
  output logic          tx_err,
  output logic          bus_idle
);
  st_e           st;
  logic          busy, owned, wr_open, is_read, stop_after;
  logic [DW-1:0] cur;
  op_e           op;
  logic          done, err;

  assign done = busy && rsp_valid;
  assign err  = done && rsp_nack && (st == ST_ADDR || st == ST_DATA);

  always_comb begin
    op = OP_NONE;
    case (st)
      ST_START: op = owned ? OP_RESTART : OP_START;
      ST_ADDR,
      ST_DATA:  op = OP_WRITE;
      ST_READ:  op = cnt_zero ? OP_NONE : OP_READ;
      ST_STOP:  op = OP_STOP;
      default:  op = OP_NONE;
    endcase
  end

  assign cmd_valid = !busy && (op != OP_NONE);
  assign cmd_op    = op;
  assign cmd_byte  = cur;
  assign cmd_nack  = (st == ST_READ) && cnt_last;

  assign pop      = !empty && (st == ST_IDLE || st == ST_CNT);
  assign flush    = err;
  assign cnt_load = (st == ST_CNT) && !empty;
  assign cnt_val  = head[DW-1:0];
  assign cnt_dec  = done && (st == ST_READ);
  assign bus_owned = owned;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      busy       <= 1'b0;
      owned      <= 1'b0;
      wr_open    <= 1'b0;
      is_read    <= 1'b0;
      stop_after <= 1'b0;
      cur        <= '0;
      tx_err     <= 1'b0;
      bus_idle   <= 1'b0;
    end else begin
      tx_err   <= err;
      bus_idle <= 1'b0;
      if (cmd_valid && cmd_ready) busy <= 1'b1;
      else if (done)              busy <= 1'b0;
      case (st)
        ST_IDLE: if (!empty) begin
          if (head[START_BIT]) begin
            cur        <= head[DW-1:0];
            is_read    <= head[0];
            stop_after <= head[STOP_BIT];
            wr_open    <= 1'b0;
            st         <= ST_START;
          end else if (wr_open) begin
            cur        <= head[DW-1:0];
            stop_after <= head[STOP_BIT];
            st         <= ST_DATA;
          end
        end
        ST_START: if (done) begin
          owned <= 1'b1;
          st    <= ST_ADDR;
        end
        ST_ADDR: if (done) begin
          if (rsp_nack)        st <= ST_STOP;
          else if (is_read)    st <= ST_CNT;
          else if (stop_after) st <= ST_STOP;
          else begin
            wr_open <= 1'b1;
            st      <= ST_IDLE;
          end
        end
        ST_DATA: if (done) begin
          if (rsp_nack) begin
            wr_open <= 1'b0;
            st      <= ST_STOP;
          end else if (stop_after) st <= ST_STOP;
          else                     st <= ST_IDLE;
        end
        ST_CNT: if (!empty) begin
          stop_after <= head[STOP_BIT];
          st         <= ST_READ;
        end
        ST_READ: if (cnt_zero && !busy) st <= stop_after ? ST_STOP : ST_IDLE;
        ST_STOP: if (done) begin
          owned    <= 1'b0;
          wr_open  <= 1'b0;
          bus_idle <= 1'b1;
          st       <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2c_cmd_seq.sv
module i2c_cmd_seq #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  parameter int EW    = DW + 2,
  parameter int OW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [EW-1:0] in_data,
  output logic [OW-1:0] occ_m1,
  output logic          fifo_empty,
  output logic          cmd_valid,
  input  logic          cmd_ready,
  output logic [2:0]    cmd_op,
  output logic [DW-1:0] cmd_byte,
  output logic          cmd_nack,
  input  logic          rsp_valid,
  input  logic          rsp_nack,
  output logic          bus_owned,
  output logic          tx_err,
  output logic          bus_idle
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [EW-1:0] head;
  logic          empty, full, pop, flush;
  logic [CW-1:0] count;
  logic          cnt_load, cnt_dec, cnt_zero, cnt_last;
  logic [DW-1:0] cnt_val;
  logic [CW-1:0] count_m1;

  assign in_ready   = !full && !flush;
  assign fifo_empty = empty;
  assign count_m1   = count - 1'b1;
  assign occ_m1     = empty ? '0 : count_m1[OW-1:0];

  i2c_seq_fifo #(.W(EW), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .push(in_valid && in_ready), .push_data(in_data),
    .pop(pop), .head(head), .empty(empty), .full(full), .count(count)
  );

  i2c_seq_rdcnt #(.DW(DW)) u_rdcnt (
    .clk(clk), .rst_n(rst_n), .load(cnt_load), .load_val(cnt_val),
    .dec(cnt_dec), .zero(cnt_zero), .last(cnt_last)
  );

  i2c_seq_ctrl #(.DW(DW), .EW(EW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .head(head), .empty(empty), .pop(pop),
    .flush(flush), .cnt_load(cnt_load), .cnt_val(cnt_val),
    .cnt_dec(cnt_dec), .cnt_zero(cnt_zero), .cnt_last(cnt_last),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_byte(cmd_byte), .cmd_nack(cmd_nack), .rsp_valid(rsp_valid),
    .rsp_nack(rsp_nack), .bus_owned(bus_owned), .tx_err(tx_err),
    .bus_idle(bus_idle)
  );
endmodule

// File: rtl/i2c_cmd_seq_chk.sv
module i2c_cmd_seq_chk #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  parameter int OW    = $clog2(DEPTH)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_ready,
  input logic [OW-1:0] occ_m1,
  input logic          fifo_empty,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic [2:0]    cmd_op,
  input logic [DW-1:0] cmd_byte,
  input logic          cmd_nack,
  input logic          bus_owned,
  input logic          tx_err,
  input logic          bus_idle
);
  // R1: a full queue refuses entries
  p_full_blocks_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_empty && occ_m1 == OW'(DEPTH - 1)) |-> !in_ready);

  // R11: an offered command holds steady until taken
  p_cmd_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=>
      (cmd_valid && $stable(cmd_op) && $stable(cmd_byte) && $stable(cmd_nack)));

  // R3: repeated start only while owning the bus
  p_restart_owned_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd2) |-> bus_owned);

  // R3: a released bus only ever sees a plain start
  p_start_free_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !bus_owned) |-> (cmd_op == 3'd1));

  // R8: the error pulse coincides with an emptied queue
  p_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_err |-> fifo_empty);

  // R8: error is a single-cycle pulse
  p_err_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_err |=> !tx_err);

  // R9: bus release pulse comes with ownership dropped
  p_idle_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_idle |-> !bus_owned);
endmodule

bind i2c_cmd_seq i2c_cmd_seq_chk #(.DEPTH(DEPTH), .DW(DW), .OW(OW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .occ_m1(occ_m1),
  .fifo_empty(fifo_empty), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_op(cmd_op), .cmd_byte(cmd_byte), .cmd_nack(cmd_nack),
  .bus_owned(bus_owned), .tx_err(tx_err), .bus_idle(bus_idle)
);

// File: tb/sim_i2c_cmd_seq.sv
`timescale 1ns/1ps
module sim_i2c_cmd_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [9:0] in_data = '0;
  logic       in_ready;
  logic [3:0] occ_m1;
  logic       fifo_empty, cmd_valid, cmd_nack, bus_owned, tx_err, bus_idle;
  logic       cmd_ready = 1'b0, rsp_valid = 1'b0, rsp_nack = 1'b0;
  logic [2:0] cmd_op;
  logic [7:0] cmd_byte;

  always #2.5 clk = ~clk;

  i2c_cmd_seq u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .occ_m1(occ_m1), .fifo_empty(fifo_empty),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_byte(cmd_byte), .cmd_nack(cmd_nack), .rsp_valid(rsp_valid),
    .rsp_nack(rsp_nack), .bus_owned(bus_owned), .tx_err(tx_err),
    .bus_idle(bus_idle)
  );

  int total = 0, bad = 0, cyc = 0;
  int log_n = 0, exp_n = 0, nack_at = -1, pend = 0;
  int txe_n = 0, bidle_n = 0, flush_bad = 0;
  bit stall = 0, pend_nack = 0, finished = 0;
  int log_v [64];
  int exp_v [64];

  function automatic int pack(int op, int b, int n);
    return op * 1000 + ((op == 3) ? b : 0) * 2 + ((op == 4) ? n : 0);
  endfunction

  // bit-engine model
  always @(negedge clk) begin
    cyc++;
    if (tx_err) begin
      txe_n++;
      if (!fifo_empty) flush_bad++;
    end
    if (bus_idle) bidle_n++;
    rsp_valid = 1'b0;
    rsp_nack  = 1'b0;
    if (pend > 0) begin
      cmd_ready = 1'b0;
      pend--;
      if (pend == 0) begin
        rsp_valid = 1'b1;
        rsp_nack  = pend_nack;
      end
    end else begin
      cmd_ready = !stall && (cyc % 3 != 0);
      if (cmd_valid && cmd_ready) begin
        if (log_n < 64) log_v[log_n] = pack(int'(cmd_op), int'(cmd_byte), int'(cmd_nack));
        pend_nack = (log_n == nack_at);
        log_n++;
        pend = 2;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, expv);
    end
  endtask

  task automatic push(input logic [9:0] d);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    in_data  = d;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic settle();
    int quiet = 0;
    for (int i = 0; i < 3000 && quiet < 8; i++) begin
      @(negedge clk);
      if (fifo_empty && !bus_owned && !cmd_valid && pend == 0) quiet++;
      else quiet = 0;
    end
  endtask

  task automatic begin_s();
    log_n = 0; exp_n = 0; txe_n = 0; bidle_n = 0; nack_at = -1;
  endtask

  task automatic ex(input int op, input int b, input int n);
    if (exp_n < 64) exp_v[exp_n] = pack(op, b, n);
    exp_n++;
  endtask

  task automatic compare(input string req);
    chk(log_n == exp_n, {req, " command count"}, log_n, exp_n);
    for (int i = 0; i < exp_n && i < log_n && i < 64; i++)
      chk(log_v[i] == exp_v[i], {req, " command"}, log_v[i], exp_v[i]);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state (R1, R2)
    chk(fifo_empty == 1'b1, "R2 reset empty", fifo_empty, 1);
    chk(occ_m1 == 4'd0, "R2 reset occ", occ_m1, 0);
    chk(in_ready == 1'b1, "R1 reset ready", in_ready, 1);
    chk(cmd_valid == 1'b0 && bus_owned == 1'b0, "R9 reset idle", cmd_valid, 0);

    // A: occupancy sweep against a stalled engine, 16-byte write (R1 R2 R3 R4 R9)
    begin_s();
    stall = 1;
    push(10'h1A0);
    @(negedge clk);
    chk(fifo_empty == 1'b1, "R2 empty after pop", fifo_empty, 1);
    for (int k = 1; k <= 16; k++) begin
      push({(k == 16), 1'b0, 8'((k * 7 + 3) & 8'hFF)});
      chk(occ_m1 == 4'(k - 1) && !fifo_empty, "R2 occupancy", occ_m1, k - 1);
    end
    chk(in_ready == 1'b0, "R1 full refuses", in_ready, 0);
    stall = 0;
    settle();
    ex(1, 0, 0); ex(3, 8'hA0, 0);
    for (int k = 1; k <= 16; k++) ex(3, (k * 7 + 3) & 8'hFF, 0);
    ex(5, 0, 0);
    compare("R4 long write");
    chk(bidle_n == 1, "R9 bus idle pulses", bidle_n, 1);
    chk(txe_n == 0, "R8 no error", txe_n, 0);

    // B: address-only write with stop (R5)
    begin_s();
    push(10'h3A0);
    settle();
    ex(1, 0, 0); ex(3, 8'hA0, 0); ex(5, 0, 0);
    compare("R5 addr only");
    chk(bidle_n == 1, "R5 stop completes", bidle_n, 1);

    // C: read count sweep (R6)
    for (int n = 0; n <= 5; n++) begin
      begin_s();
      push(10'h1A5);
      push({2'b10, 8'(n)});
      settle();
      ex(1, 0, 0); ex(3, 8'hA5, 0);
      for (int j = 1; j <= n; j++) ex(4, 0, (j == n) ? 1 : 0);
      ex(5, 0, 0);
      compare("R6 read count");
    end

    // D: write without stop then repeated-start read (R3 R6)
    begin_s();
    push(10'h190);
    push(10'h011);
    push(10'h191);
    push(10'h202);
    settle();
    ex(1, 0, 0); ex(3, 8'h90, 0); ex(3, 8'h11, 0);
    ex(2, 0, 0); ex(3, 8'h91, 0); ex(4, 0, 0); ex(4, 0, 1); ex(5, 0, 0);
    compare("R3 repeated start");
    chk(bidle_n == 1, "R9 single release", bidle_n, 1);

    // E: queue drains mid-write (R7)
    begin_s();
    push(10'h1C0);
    push(10'h022);
    repeat (40) @(negedge clk);
    chk(bus_owned == 1'b1, "R7 bus held", bus_owned, 1);
    chk(cmd_valid == 1'b0, "R7 no command", cmd_valid, 0);
    chk(log_n == 3, "R7 commands so far", log_n, 3);
    push(10'h233);
    settle();
    ex(1, 0, 0); ex(3, 8'hC0, 0); ex(3, 8'h22, 0); ex(3, 8'h33, 0); ex(5, 0, 0);
    compare("R7 resume");

    // F1: no acknowledge on address (R8)
    begin_s();
    nack_at = 1;
    stall = 1;
    push(10'h140); push(10'h001); push(10'h002); push(10'h203);
    stall = 0;
    settle();
    ex(1, 0, 0); ex(3, 8'h40, 0); ex(5, 0, 0);
    compare("R8 addr nack");
    chk(txe_n == 1, "R8 error pulse", txe_n, 1);
    chk(bidle_n == 1, "R8 stop after error", bidle_n, 1);

    // F2: no acknowledge on second data byte (R8)
    begin_s();
    nack_at = 3;
    stall = 1;
    push(10'h140); push(10'h0A1); push(10'h0A2); push(10'h0A3); push(10'h2A4);
    stall = 0;
    settle();
    ex(1, 0, 0); ex(3, 8'h40, 0); ex(3, 8'hA1, 0); ex(3, 8'hA2, 0); ex(5, 0, 0);
    compare("R8 data nack");
    chk(txe_n == 1, "R8 data error pulse", txe_n, 1);
    chk(flush_bad == 0, "R8 flushed with error", flush_bad, 0);

    // G: stray data entries (R10)
    begin_s();
    push(10'h055);
    repeat (20) @(negedge clk);
    chk(log_n == 0 && fifo_empty, "R10 idle stray dropped", log_n, 0);
    push(10'h1B1);
    push(10'h001);
    push(10'h077);
    push(10'h320);
    settle();
    ex(1, 0, 0); ex(3, 8'hB1, 0); ex(4, 0, 1);
    ex(2, 0, 0); ex(3, 8'h20, 0); ex(5, 0, 0);
    compare("R10 stray after read");

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule